// File: doc/BRIEF.md
# Instruction Breakpoint and Data Watchpoint Comparator

This block watches a 32-bit CPU's instruction fetch and data access streams and flags accesses that match addresses loaded by a debug agent. It has a parameterized set of breakpoint slots and a parameterized set of watchpoint slots.

A breakpoint slot fires when an enabled slot's stored address equals the program counter of the instruction being fetched. A watchpoint slot fires when the data access address equals its stored byte address and the direction of the access passes the slot's two-bit mode filter.

Both hit signals are combinational from the current inputs and the slot registers. A hit is therefore visible in the same cycle as the access, early enough for the pipeline to cancel a store before memory changes or a load before its destination register is written. The hits are reported on separate outputs with separate cause codes. A breakpoint takes priority over a watchpoint in the same cycle.

Slots are programmed through a single register-write port. A write takes effect at the next clock edge.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset every breakpoint and watchpoint slot is disabled with a stored address of zero, so no access raises a hit, including accesses to address zero.
- R2: `bp_hit` is high in the same cycle that `fetch_vld` is high and `fetch_pc` equals the address of an enabled breakpoint slot. It is low when `fetch_vld` is low or when the addresses differ.
- R3: A watchpoint in mode 2'b00 (off) never raises `wp_hit`, whatever its address or enable bit.
- R4: A watchpoint in mode 2'b01 (load) hits on a valid access with `dacc_we`=0 to its address, in the same cycle as the access. It ignores stores.
- R5: A watchpoint in mode 2'b10 (store) hits on a valid access with `dacc_we`=1 to its address. It ignores loads.
- R6: A watchpoint in mode 2'b11 (any) hits on both loads and stores to its address.
- R7: A watchpoint covers exactly one byte: an access address one above or one below the stored address does not hit.
- R8: A slot whose enable bit is cleared never hits, whatever its mode.
- R9: When a breakpoint and a watchpoint match in the same cycle, `bp_hit` is raised and `wp_hit` is held low.
- R10: `hit_cause` is 2'b01 on a breakpoint hit, 2'b10 on a watchpoint hit, and 2'b00 when nothing hits.
- R11: A configuration write (`cfg_we`=1) changes the selected slot only at the next rising clock edge. An access in the write cycle still sees the old slot contents.
- R12: `cfg_wp`=0 selects breakpoint slot `cfg_idx`, and `cfg_wp`=1 selects watchpoint slot `cfg_idx`. A match on any enabled slot, not only slot 0, is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Selects the slot bank: 0 breakpoint, 1 watchpoint |
| cfg_idx | input | IDX_W | Slot index within the bank |
| cfg_addr | input | ADDR_W | Address to store in the slot |
| cfg_en | input | 1 | Enable bit to store in the slot |
| cfg_mode | input | 2 | Watchpoint mode (00 off, 01 load, 10 store, 11 any); ignored for breakpoints |
| fetch_vld | input | 1 | Fetch program counter is valid |
| fetch_pc | input | ADDR_W | Program counter of the instruction about to execute |
| dacc_vld | input | 1 | Data access is valid |
| dacc_we | input | 1 | Data access direction: 1 store, 0 load |
| dacc_addr | input | ADDR_W | Byte address of the data access |
| bp_hit | output | 1 | Breakpoint matched this cycle |
| wp_hit | output | 1 | Watchpoint matched this cycle and no breakpoint matched |
| hit_cause | output | 2 | Cause code: 00 none, 01 breakpoint, 10 watchpoint |

## Verification
On every cycle, the assertions check the following properties:
- An off or disabled watchpoint stays silent.
- A store hit comes only from a slot whose mode admits stores.
- Neither hit appears without its valid strobe.
- Breakpoint priority and the cause code agree with the hit pulses.
- A configuration write loads exactly the written values on the following edge.

Only the bench scenarios can show the positive cases:
- A programmed address really matches in the same cycle.
- Each mode admits the correct direction.
- The single-byte window is exact.
- A slot other than zero responds.
- An access in the write cycle still sees the old configuration.

// File: rtl/dbgtrig_pkg.sv
`timescale 1ns/1ps
package dbgtrig_pkg;

  // Watchpoint direction filter; bit 0 admits loads, bit 1 admits stores.
  typedef enum logic [1:0] {
    WMODE_OFF   = 2'b00,
    WMODE_LOAD  = 2'b01,
    WMODE_STORE = 2'b10,
    WMODE_ANY   = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_BKPT  = 2'b01,
    CAUSE_WATCH = 2'b10
  } cause_e;

  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbgtrig_bp_slot.sv
`timescale 1ns/1ps
module dbgtrig_bp_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en_bit,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              match
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              en_q, en_d;

  // next state
  always_comb begin
    addr_d = addr_q;
    en_d   = en_q;
    if (wr_sel) begin
      addr_d = wr_addr;
      en_d   = wr_en_bit;
    end
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_sel) begin
      addr_q <= addr_d;
      en_q   <= en_d;
    end
  end

  assign match = en_q & fetch_vld & (fetch_pc == addr_q);

  AST_BP_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (addr_q == $past(wr_addr)) && (en_q == $past(wr_en_bit))); // R11

  AST_BP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> fetch_vld && en_q); // R2

endmodule

// File: rtl/dbgtrig_wp_slot.sv
`timescale 1ns/1ps
module dbgtrig_wp_slot
  import dbgtrig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en_bit,
  input  logic [1:0]        wr_mode,
  input  logic              dacc_vld,
  input  logic              dacc_we,
  input  logic [ADDR_W-1:0] dacc_addr,
  output logic              match
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              en_q, en_d;
  wmode_e            mode_q, mode_d;
  logic              dir_ok;

  // next state
  always_comb begin
    addr_d = addr_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (wr_sel) begin
      addr_d = wr_addr;
      en_d   = wr_en_bit;
      mode_d = wmode_e'(wr_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      mode_q <= WMODE_OFF;
    end else if (wr_sel) begin
      addr_q <= addr_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  // direction filter: a store needs the store bit, a load needs the load bit
  always_comb begin
    unique case (mode_q)
      WMODE_LOAD:  dir_ok = ~dacc_we;
      WMODE_STORE: dir_ok = dacc_we;
      WMODE_ANY:   dir_ok = 1'b1;
      default:     dir_ok = 1'b0;
    endcase
  end

  // single-byte window: exact address equality
  assign match = en_q & dacc_vld & dir_ok & (dacc_addr == addr_q);

  AST_WP_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WMODE_OFF || !en_q) |-> !match); // R3

  AST_WP_STORE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (match && dacc_we) |-> mode_q[1]); // R5

  AST_WP_LOAD_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !dacc_we) |-> mode_q[0]); // R4

  AST_WP_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (addr_q == $past(wr_addr)) && (mode_q == $past(wr_mode))); // R11

endmodule

// File: rtl/dbgtrig_arbiter.sv
`timescale 1ns/1ps
module dbgtrig_arbiter
  import dbgtrig_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input  logic [NUM_BP-1:0] bp_vec,
  input  logic [NUM_WP-1:0] wp_vec,
  output logic              bp_hit,
  output logic              wp_hit,
  output logic [1:0]        hit_cause
);

  logic bp_any, wp_any;
  cause_e cause;

  assign bp_any = |bp_vec;
  assign wp_any = |wp_vec;

  // breakpoint wins; watchpoint suppressed in the same cycle
  always_comb begin
    bp_hit = bp_any;
    wp_hit = wp_any & ~bp_any;
    if (bp_any)      cause = CAUSE_BKPT;
    else if (wp_any) cause = CAUSE_WATCH;
    else             cause = CAUSE_NONE;
  end

  assign hit_cause = cause;

endmodule

// File: rtl/dbg_trigger_unit.sv
`timescale 1ns/1ps
module dbg_trigger_unit
  import dbgtrig_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  localparam int IDX_W = idx_bits((NUM_BP > NUM_WP) ? NUM_BP : NUM_WP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wp,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              dacc_vld,
  input  logic              dacc_we,
  input  logic [ADDR_W-1:0] dacc_addr,
  output logic              bp_hit,
  output logic              wp_hit,
  output logic [1:0]        hit_cause
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_BP-1:0] bp_vec;
  logic [NUM_WP-1:0] wp_vec;

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    logic sel;
    assign sel = cfg_we & ~cfg_wp & (cfg_idx == IDX_W'(b));
    dbgtrig_bp_slot #(.ADDR_W(ADDR_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_sel    (sel),
      .wr_addr   (cfg_addr),
      .wr_en_bit (cfg_en),
      .fetch_vld (fetch_vld),
      .fetch_pc  (fetch_pc),
      .match     (bp_vec[b])
    );
  end

  for (genvar w = 0; w < NUM_WP; w++) begin : g_wp
    logic sel;
    assign sel = cfg_we & cfg_wp & (cfg_idx == IDX_W'(w));
    dbgtrig_wp_slot #(.ADDR_W(ADDR_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_sel    (sel),
      .wr_addr   (cfg_addr),
      .wr_en_bit (cfg_en),
      .wr_mode   (cfg_mode),
      .dacc_vld  (dacc_vld),
      .dacc_we   (dacc_we),
      .dacc_addr (dacc_addr),
      .match     (wp_vec[w])
    );
  end

  dbgtrig_arbiter #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) i_arb (
    .bp_vec    (bp_vec),
    .wp_vec    (wp_vec),
    .bp_hit    (bp_hit),
    .wp_hit    (wp_hit),
    .hit_cause (hit_cause)
  );

  AST_BP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|bp_vec && |wp_vec) |-> (bp_hit && !wp_hit)); // R9

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({bp_hit, wp_hit})); // R9

  AST_CAUSE_BKPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    bp_hit |-> (hit_cause == CAUSE_BKPT)); // R10

  AST_CAUSE_WATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    wp_hit |-> (hit_cause == CAUSE_WATCH)); // R10

  AST_NO_WP_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dacc_vld |-> !wp_hit); // R4

  AST_NO_BP_WITHOUT_FETCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fetch_vld |-> !bp_hit); // R2

endmodule

// File: tb/test_dbg_trigger_unit.sv
`timescale 1ns/1ps
module test_dbg_trigger_unit;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_wp, cfg_en;
  logic [1:0]    cfg_idx;
  logic [AW-1:0] cfg_addr;
  logic [1:0]    cfg_mode;
  logic          fetch_vld, dacc_vld, dacc_we;
  logic [AW-1:0] fetch_pc, dacc_addr;
  logic          bp_hit, wp_hit;
  logic [1:0]    hit_cause;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  dbg_trigger_unit i_dbg_trigger_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wp(cfg_wp), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .dacc_vld(dacc_vld), .dacc_we(dacc_we), .dacc_addr(dacc_addr),
    .bp_hit(bp_hit), .wp_hit(wp_hit), .hit_cause(hit_cause)
  );

  // monitor: compare each expected item mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({bp_hit, wp_hit, hit_cause} !== e) begin
        n_fail++;
        $display("FAIL %s: got bp=%b wp=%b cause=%b, expected bp=%b wp=%b cause=%b",
                 t, bp_hit, wp_hit, hit_cause, e[3], e[2], e[1:0]);
      end
    end
  end

  task automatic push(input logic eb, input logic ew, input logic [1:0] ec, input string t);
    exp_q.push_back({eb, ew, ec});
    tag_q.push_back(t);
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_wp = 0; cfg_idx = 0; cfg_addr = '0; cfg_en = 0; cfg_mode = 2'b00;
    fetch_vld = 0; fetch_pc = '0; dacc_vld = 0; dacc_we = 0; dacc_addr = '0;
  endtask

  task automatic cfg_write(input logic wp, input logic [1:0] idx, input logic [AW-1:0] a,
                           input logic en, input logic [1:0] mode);
    @(posedge clk); #1;
    fetch_vld = 0; dacc_vld = 0;
    cfg_we = 1; cfg_wp = wp; cfg_idx = idx; cfg_addr = a; cfg_en = en; cfg_mode = mode;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  // driver: apply one access cycle and queue its expected outputs
  task automatic probe(input logic fv, input logic [AW-1:0] pc,
                       input logic dv, input logic dw, input logic [AW-1:0] da,
                       input logic eb, input logic ew, input logic [1:0] ec, input string t);
    @(posedge clk); #1;
    fetch_vld = fv; fetch_pc = pc; dacc_vld = dv; dacc_we = dw; dacc_addr = da;
    push(eb, ew, ec, t);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: everything disabled after reset, address zero included
    probe(1, 32'h0, 1, 0, 32'h0, 0, 0, 2'b00, "R1 load at 0");
    probe(1, 32'h0, 1, 1, 32'h0, 0, 0, 2'b00, "R1 store at 0");

    // R2 / R10
    cfg_write(0, 2'd0, 32'h0000_1000, 1, 2'b00);
    probe(1, 32'h0000_1000, 0, 0, 32'h0, 1, 0, 2'b01, "R2 bp match");
    probe(0, 32'h0000_1000, 0, 0, 32'h0, 0, 0, 2'b00, "R2 no fetch_vld");
    probe(1, 32'h0000_1004, 0, 0, 32'h0, 0, 0, 2'b00, "R2 pc differs");

    // R12: another breakpoint slot
    cfg_write(0, 2'd2, 32'h0000_2000, 1, 2'b00);
    probe(1, 32'h0000_2000, 0, 0, 32'h0, 1, 0, 2'b01, "R12 bp slot 2");

    // R4: load-only watchpoint in slot 1
    cfg_write(1, 2'd1, 32'h8000_0003, 1, 2'b01);
    probe(0, 32'h0, 1, 0, 32'h8000_0003, 0, 1, 2'b10, "R4 load hits");
    probe(0, 32'h0, 1, 1, 32'h8000_0003, 0, 0, 2'b00, "R4 store ignored");
    probe(0, 32'h0, 0, 0, 32'h8000_0003, 0, 0, 2'b00, "R4 no dacc_vld");
    // R7
    probe(0, 32'h0, 1, 0, 32'h8000_0004, 0, 0, 2'b00, "R7 byte above");
    probe(0, 32'h0, 1, 0, 32'h8000_0002, 0, 0, 2'b00, "R7 byte below");

    // R5
    cfg_write(1, 2'd1, 32'h8000_0003, 1, 2'b10);
    probe(0, 32'h0, 1, 1, 32'h8000_0003, 0, 1, 2'b10, "R5 store hits");
    probe(0, 32'h0, 1, 0, 32'h8000_0003, 0, 0, 2'b00, "R5 load ignored");

    // R6
    cfg_write(1, 2'd1, 32'h8000_0003, 1, 2'b11);
    probe(0, 32'h0, 1, 0, 32'h8000_0003, 0, 1, 2'b10, "R6 load hits");
    probe(0, 32'h0, 1, 1, 32'h8000_0003, 0, 1, 2'b10, "R6 store hits");

    // R3: enabled but mode off
    cfg_write(1, 2'd3, 32'h0000_0040, 1, 2'b00);
    probe(0, 32'h0, 1, 0, 32'h0000_0040, 0, 0, 2'b00, "R3 off load");
    probe(0, 32'h0, 1, 1, 32'h0000_0040, 0, 0, 2'b00, "R3 off store");

    // R9: breakpoint and watchpoint together
    probe(1, 32'h0000_1000, 1, 0, 32'h8000_0003, 1, 0, 2'b01, "R9 bp over wp");

    // R8: enable bit cleared
    cfg_write(1, 2'd1, 32'h8000_0003, 0, 2'b11);
    probe(0, 32'h0, 1, 1, 32'h8000_0003, 0, 0, 2'b00, "R8 wp disabled");
    cfg_write(0, 2'd0, 32'h0000_1000, 0, 2'b00);
    probe(1, 32'h0000_1000, 0, 0, 32'h0, 0, 0, 2'b00, "R8 bp disabled");

    // R11: write cycle still sees old contents, next cycle the new ones
    @(posedge clk); #1;
    cfg_we = 1; cfg_wp = 0; cfg_idx = 2'd1; cfg_addr = 32'h0000_3000; cfg_en = 1; cfg_mode = 2'b00;
    fetch_vld = 1; fetch_pc = 32'h0000_3000; dacc_vld = 0;
    push(0, 0, 2'b00, "R11 write cycle old value");
    @(posedge clk); #1;
    cfg_we = 0;
    push(1, 0, 2'b01, "R11 after edge new value");

    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule